// File: doc/BRIEF.md
# Split-Edge Register File

This block is the architectural register store of a five-stage integer pipeline. It holds a bank of general-purpose registers, serves two operand reads per cycle for the decode stage, and accepts one result per cycle from the write-back stage. Each read port takes a register number, picks that register through a selector, and captures it into an output register on the rising clock edge.

The write port commits on the falling clock edge, half a cycle ahead of the next read capture. An instruction in write-back and an instruction in decode that names the same register therefore need no bypass path inside the file. The value written in the first half of the cycle is what the read port captures at the end of the cycle. Register zero is hard-wired to zero. A synchronous reset returns every register to zero.

Top module: `dual_edge_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, the storage (on falling edges) and both read outputs (on rising edges) clear to zero. After reset, every register number read on either port returns zero.
- R2: On each rising edge, `rd_data_a` captures the register selected by the 5-bit number on `rd_addr_a`, with the bank contents as they stand at that edge. The output changes at no other time.
- R3: When `wr_en` is 1 at a falling edge, `wr_data` is stored into the register numbered by `wr_addr`.
- R4: When `wr_en` is 0 at a falling edge, no register changes, whatever `wr_addr` and `wr_data` hold.
- R5: Register number 0 always reads as zero. A write that names it is discarded.
- R6: A write committed on a falling edge is returned by a read of the same register captured on the next rising edge.
- R7: Port B behaves as port A does, using `rd_addr_b` and `rd_data_b`. Both ports may read the same register or different registers in one cycle, and a write to one register leaves all other registers unchanged.
- R8: Between two rising edges a read output holds its value, even when the register it was read from is overwritten on the intervening falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; reads on rising edge, writes on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable for the write-back port |
| wr_addr | input | 5 | Destination register number |
| wr_data | input | 32 | Value to store |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_a | output | 32 | Registered read result, port A |
| rd_data_b | output | 32 | Registered read result, port B |

## Verification
The bound checker keeps its own shadow of the bank, updated from the write port on falling edges. On every cycle it checks that both read outputs match the shadow at the rising edge, that register zero reads zero, that reset clears the outputs, and that a falling-edge write shows up on the following rising-edge read. Only the bench scenarios can show the mid-cycle hold of an output whose register has just been overwritten. The same is true of the full sweeps: every register written, every register read back on both ports, and a disabled-write sweep that leaves contents untouched.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int RF_DEPTH      = 32;
    localparam int RF_WIDTH      = 32;
    localparam int RF_READ_PORTS = 2;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    output logic [DEPTH-1:0] wr_sel
);
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_sel
            if (i == 0) begin : g_zero
                // register zero is never a write target
                assign wr_sel[i] = 1'b0;
            end else begin : g_reg
                assign wr_sel[i] = wr_en && (wr_addr == AW'(i));
            end
        end
    endgenerate
endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DEPTH-1:0]          wr_sel,
    input  logic [DW-1:0]             wr_data,
    output logic [DEPTH-1:0][DW-1:0]  regs_q
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] regs;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (rst) begin
            bank_d.regs = '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_sel[i]) bank_d.regs[i] = wr_data;
            end
        end
    end

    // writes commit on the falling edge, half a cycle before read capture
    always_ff @(negedge clk) begin
        bank_q <= bank_d;
    end

    assign regs_q = bank_q.regs;
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [AW-1:0]             rd_addr,
    input  logic [DEPTH-1:0][DW-1:0]  regs,
    output logic [DW-1:0]             rd_data
);
    typedef struct packed {
        logic [DW-1:0] data;
    } port_t;

    port_t port_d, port_q;

    always_comb begin
        port_d = port_q;
        if (rst || rd_addr == '0 || int'(rd_addr) >= DEPTH) begin
            port_d.data = '0;
        end else begin
            port_d.data = regs[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        port_q <= port_d;
    end

    assign rd_data = port_q.data;
endmodule

// File: rtl/dual_edge_regfile.sv
module dual_edge_regfile
    import rf_pkg::*;
#(
    parameter int DEPTH = RF_DEPTH,
    parameter int DW    = RF_WIDTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [DW-1:0] rd_data_a,
    output logic [DW-1:0] rd_data_b
);
    localparam int NRD = RF_READ_PORTS;

    logic [DEPTH-1:0]          wr_sel;
    logic [DEPTH-1:0][DW-1:0]  bank;
    logic [NRD-1:0][AW-1:0]    raddr;
    logic [NRD-1:0][DW-1:0]    rdata;

    assign raddr[0]  = rd_addr_a;
    assign raddr[1]  = rd_addr_b;
    assign rd_data_a = rdata[0];
    assign rd_data_b = rdata[1];

    rf_wr_decode #(.DEPTH(DEPTH)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel)
    );

    rf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs_q  (bank)
    );

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            rf_read_port #(.DEPTH(DEPTH), .DW(DW)) u_port (
                .clk     (clk),
                .rst     (rst),
                .rd_addr (raddr[p]),
                .regs    (bank),
                .rd_data (rdata[p])
            );
        end
    endgenerate
endmodule

// File: rtl/dual_edge_regfile_chk.sv
module dual_edge_regfile_chk #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic [AW-1:0] rd_addr_a,
    input logic [AW-1:0] rd_addr_b,
    input logic [DW-1:0] rd_data_a,
    input logic [DW-1:0] rd_data_b
);
    logic [DW-1:0] shadow [DEPTH];
    logic [DW-1:0] exp_a, exp_b;
    logic          started;

    always_ff @(negedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) shadow[i] <= '0;
            else if (wr_en && wr_addr != '0 && int'(wr_addr) == i) shadow[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        started <= 1'b1;
        exp_a   <= (rst || rd_addr_a == '0) ? '0 : shadow[rd_addr_a];
        exp_b   <= (rst || rd_addr_b == '0) ? '0 : shadow[rd_addr_b];
    end

    p_read_match_r2: assert property (@(negedge clk) disable iff (rst || !started)
        rd_data_a == exp_a);

    p_read_match_b_r7: assert property (@(negedge clk) disable iff (rst || !started)
        rd_data_b == exp_b);

    p_zero_reg_r5: assert property (@(posedge clk) disable iff (rst || !started)
        (rd_addr_a == '0) |=> (rd_data_a == '0));

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!started)
        rst |=> (rd_data_a == '0 && rd_data_b == '0));

    p_write_through_r6: assert property (@(negedge clk) disable iff (rst || !started)
        (wr_en && wr_addr != '0 && rd_addr_a == wr_addr) |=> (rd_data_a == $past(wr_data)));
endmodule

bind dual_edge_regfile dual_edge_regfile_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/tb_dual_edge_regfile.sv
`timescale 1ns/1ps
module tb_dual_edge_regfile;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic [4:0]  rd_addr_a, rd_addr_b;
    logic [31:0] rd_data_a, rd_data_b;

    logic [31:0] mdl [32];
    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    dual_edge_regfile dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
        return (32'(i) * 32'h9E37_79B9) ^ salt;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle of inputs, advance past the next rising edge
    task automatic step(input logic r, input logic we, input logic [4:0] wa,
                        input logic [31:0] wd, input logic [4:0] ra, input logic [4:0] rb);
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr_a = ra; rd_addr_b = rb;
        if (r) begin
            for (int k = 0; k < 32; k++) mdl[k] = '0;
        end else if (we && wa != 0) begin
            mdl[wa] = wd;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        for (int k = 0; k < 32; k++) mdl[k] = '0;
        rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr_a = 0; rd_addr_b = 0;
        @(posedge clk); #1;
        for (int k = 0; k < 3; k++) step(1, 1, 5'(k + 3), 32'hDEAD_0000, 5'(k + 3), 5'(k + 3));
        chk("R1 reset out a", rd_data_a, 32'h0);
        chk("R1 reset out b", rd_data_b, 32'h0);

        // every register is zero after reset
        for (int i = 0; i < 32; i++) begin
            step(0, 0, 0, 0, 5'(i), 5'(31 - i));
            chk("R1 cleared a", rd_data_a, 32'h0);
            chk("R1 cleared b", rd_data_b, 32'h0);
        end

        // write every register, reading it back in the same cycle (R3, R6)
        for (int i = 0; i < 32; i++) begin
            step(0, 1, 5'(i), pat(i, 32'hA5A5_0000), 5'(i), 5'((i + 16) % 32));
            chk(i == 0 ? "R5 write to zero ignored" : "R6 write-through", rd_data_a, mdl[i]);
            chk("R7 other register untouched", rd_data_b, mdl[(i + 16) % 32]);
        end

        // full readback on both ports (R2, R7)
        for (int i = 0; i < 32; i++) begin
            step(0, 0, 0, 0, 5'(i), 5'(31 - i));
            chk(i == 0 ? "R5 zero read" : "R2 readback a", rd_data_a, i == 0 ? 32'h0 : pat(i, 32'hA5A5_0000));
            chk("R7 readback b", rd_data_b, mdl[31 - i]);
        end

        // same register on both ports
        step(0, 0, 0, 0, 5'd9, 5'd9);
        chk("R7 shared a", rd_data_a, pat(9, 32'hA5A5_0000));
        chk("R7 shared b", rd_data_b, pat(9, 32'hA5A5_0000));

        // disabled writes change nothing (R4)
        for (int i = 0; i < 32; i++) begin
            step(0, 0, 5'(i), 32'hFFFF_FFFF, 5'(i), 5'(i));
            chk("R4 no write when disabled", rd_data_a, mdl[i]);
        end
        for (int i = 1; i < 32; i++) begin
            step(0, 0, 0, 0, 5'(i), 5'(i));
            chk("R4 contents intact", rd_data_b, pat(i, 32'hA5A5_0000));
        end

        // mid-cycle hold (R8) then capture of the new value (R6)
        step(0, 0, 0, 0, 5'd5, 5'd6);
        chk("R2 before overwrite", rd_data_a, mdl[5]);
        rst = 0; wr_en = 1; wr_addr = 5'd5; wr_data = 32'h1234_5678;
        rd_addr_a = 5'd5; rd_addr_b = 5'd6;
        @(negedge clk); #0.5;
        chk("R8 output held across falling-edge write", rd_data_a, mdl[5]);
        mdl[5] = 32'h1234_5678;
        @(posedge clk); #1;
        chk("R6 new value captured", rd_data_a, 32'h1234_5678);
        chk("R7 neighbour", rd_data_b, mdl[6]);

        // explicit attempt on register zero
        step(0, 1, 5'd0, 32'hCAFE_F00D, 5'd0, 5'd0);
        step(0, 0, 0, 0, 5'd0, 5'd5);
        chk("R5 zero stays zero", rd_data_a, 32'h0);
        chk("R3 stored value", rd_data_b, 32'h1234_5678);

        // second reset mid-run
        step(1, 0, 0, 0, 5'd5, 5'd31);
        step(0, 0, 0, 0, 5'd5, 5'd31);
        chk("R1 re-reset a", rd_data_a, 32'h0);
        chk("R1 re-reset b", rd_data_b, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule